// File: doc/BRIEF.md
# Paced Sample Feeder with Wishbone Register Port

This block hands audio-rate samples to a downstream pulse-width modulator at a fixed cadence. Software writes each sample over a Wishbone classic slave port. The sample lands in a one-entry holding slot. A free-running down-counter marks the end of every sample period. At that point the held sample becomes the active sample driven on `sample_o`, and `irq_o` rises to ask for the next one.

Because of the holding slot, a new sample can be posted as soon as the previous one has gone active. Software therefore has a full sample period to answer each interrupt. The period length is a register value in clock cycles; for example, 1814 cycles of an 80 MHz clock gives roughly 44.1 kHz. If software misses a period, the active sample repeats and the interrupt stays raised.

Top module: `wb_sample_feeder`

## Requirements
- R1: Word address 0 selects the sample register and word address 1 selects the period register. A write to address 1 stores bits [15:0] of the write data as the period, and a read of address 1 returns the period in bits [15:0] with all upper bits zero.
- R2: Each access with `wb_cyc_i` and `wb_stb_i` both high is acknowledged by `wb_ack_o` high for exactly one cycle, on the clock edge after the request is sampled. A strobe without `wb_cyc_i` gets no acknowledge and changes no state.
- R3: A write to address 0 stores bits [15:0] in the holding slot and drops `irq_o`. `sample_o` does not change until the current period ends.
- R4: A read of address 0 returns the active sample in bits [15:0] and the interrupt state in bit 16, with bits [31:17] zero.
- R5: A period ends every P clock cycles, where P is the period register value. With the slot refilled every period, successive changes of `sample_o` are exactly P cycles apart.
- R6: When a period ends with the slot full, the held sample appears on `sample_o` and `irq_o` rises on the same clock edge. Samples go active in the order they were written.
- R7: When a period ends with the slot empty, `sample_o` keeps its value and `irq_o` stays high.
- R8: A second write to address 0 before the period ends replaces the held sample. Only the latest value goes active, and `irq_o` stays low until that happens.
- R9: A new period value takes effect after the period in progress has ended. The period in progress keeps its old length.
- R10: After reset, `sample_o` is 0, `irq_o` is 1, the slot is empty and the period register holds the parameter `RST_RELOAD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADR_W (1) | Word address |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_dat_o | output | DATA_W (32) | Read data, valid while `wb_ack_o` is high |
| wb_ack_o | output | 1 | Transfer acknowledge |
| sample_o | output | SAMPLE_W (16) | Active sample for the modulator |
| irq_o | output | 1 | High while the holding slot is empty |

## Verification
A bus write or read is sampled on the first rising edge after the strobe is driven. Its acknowledge, and any read data, are checked at the falling edge that follows that edge. The acknowledge is then checked to be low one cycle later.

A promotion is due on the edge where the period counter expires. A monitor watches `sample_o` at every falling edge. When it sees a change, it takes the next expected sample from the scoreboard queue, checks that `irq_o` is already high, and compares the rising-edge count since the previous change with the expected period. The one interval that follows a period change or an idle gap is excluded from that comparison.

Hold and ignore cases are checked after waiting out at least two whole periods.

// File: rtl/wbsf_pkg.sv
package wbsf_pkg;

  typedef enum logic [1:0] {
    SEL_SAMPLE = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_NONE   = 2'd2
  } wbsf_sel_e;

  // word address decode; bit positions are part of the register contract
  function automatic wbsf_sel_e decode_addr(input logic [31:0] adr);
    case (adr)
      32'd0:   return SEL_SAMPLE;
      32'd1:   return SEL_PERIOD;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wbsf_regs.sv
module wbsf_regs
  import wbsf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADR_W      = 1,
  parameter int SAMPLE_W   = 16,
  parameter int CNT_W      = 16,
  parameter int RST_RELOAD = 1814
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADR_W-1:0]    adr_i,
  input  logic [DATA_W-1:0]   dat_i,
  output logic [DATA_W-1:0]   dat_o,
  output logic                ack_o,
  input  logic [SAMPLE_W-1:0] active_i,
  input  logic                irq_i,
  output logic [CNT_W-1:0]    period_o,
  output logic                wr_sample_o,
  output logic [SAMPLE_W-1:0] sample_wdata_o
);

  localparam int USED_W = (SAMPLE_W > CNT_W) ? SAMPLE_W : CNT_W;

  logic              ack_q;
  logic [DATA_W-1:0] rdat_q;
  logic [CNT_W-1:0]  period_q;
  logic              req;
  wbsf_sel_e         sel;
  logic [DATA_W-1:0] rdata;

  // one transfer per strobe even if the master holds it through the ack
  assign req = cyc_i & stb_i & ~ack_q;
  assign sel = decode_addr(32'(adr_i));

  assign wr_sample_o    = req & we_i & (sel == SEL_SAMPLE);
  assign sample_wdata_o = dat_i[SAMPLE_W-1:0];

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_SAMPLE: begin
        rdata[SAMPLE_W-1:0] = active_i;
        rdata[SAMPLE_W]     = irq_i;
      end
      SEL_PERIOD: rdata[CNT_W-1:0] = period_q;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      rdat_q   <= '0;
      period_q <= CNT_W'(RST_RELOAD);
    end else begin
      ack_q <= req;
      if (req && !we_i) rdat_q <= rdata;
      if (req && we_i && (sel == SEL_PERIOD)) period_q <= dat_i[CNT_W-1:0];
    end
  end

  assign ack_o    = ack_q;
  assign dat_o    = rdat_q;
  assign period_o = period_q;

  generate
    if (USED_W < DATA_W) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^dat_i[DATA_W-1:USED_W];
    end
  endgenerate

  // R2
  ack_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(cyc_i && stb_i));

  // R2
  req_gets_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !ack_q) |=> ack_q);

  // R1
  period_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && we_i && sel == SEL_PERIOD) |=> period_q == $past(dat_i[CNT_W-1:0]));

endmodule

// File: rtl/wbsf_rate_timer.sv
module wbsf_rate_timer #(
  parameter int CNT_W      = 16,
  parameter int RST_RELOAD = 1814
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);

  localparam logic [CNT_W-1:0] RST_CNT =
    (RST_RELOAD == 0) ? '0 : CNT_W'(RST_RELOAD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_load;

  // a zero period behaves as one cycle
  assign cnt_load = (period_i == '0) ? '0 : period_i - CNT_W'(1);
  assign tick_o   = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_CNT;
    else if (tick_o) cnt_q <= cnt_load;
    else             cnt_q <= cnt_q - CNT_W'(1);
  end

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/wbsf_sample_stage.sv
module wbsf_sample_stage #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                irq_o
);

  logic [SAMPLE_W-1:0] hold_q;
  logic [SAMPLE_W-1:0] active_q;
  logic                full_q;
  logic                irq_q;
  logic                promote;

  assign promote = tick_i & full_q;

  // same-edge write and promotion: old held value goes active, new one is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      active_q <= '0;
      full_q   <= 1'b0;
      irq_q    <= 1'b1;
    end else begin
      if (promote) active_q <= hold_q;
      if (wr_i) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
        irq_q  <= 1'b0;
      end else if (promote) begin
        full_q <= 1'b0;
        irq_q  <= 1'b1;
      end
    end
  end

  assign sample_o = active_q;
  assign irq_o    = irq_q;

  // R6
  promote_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promote |=> active_q == $past(hold_q));

  // R6
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (promote && !wr_i) |=> irq_q);

  // R7
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !full_q) |=> $stable(active_q));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(active_q));

  // R3
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!irq_q && full_q));

  // R8
  irq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == !full_q);

endmodule

// File: rtl/wb_sample_feeder.sv
module wb_sample_feeder #(
  parameter int DATA_W     = 32,
  parameter int ADR_W      = 1,
  parameter int SAMPLE_W   = 16,
  parameter int CNT_W      = 16,
  parameter int RST_RELOAD = 1814
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADR_W-1:0]    wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                irq_o
);

  logic [CNT_W-1:0]    period;
  logic                tick;
  logic                wr_sample;
  logic [SAMPLE_W-1:0] sample_wdata;

  wbsf_regs #(
    .DATA_W    (DATA_W),
    .ADR_W     (ADR_W),
    .SAMPLE_W  (SAMPLE_W),
    .CNT_W     (CNT_W),
    .RST_RELOAD(RST_RELOAD)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cyc_i         (wb_cyc_i),
    .stb_i         (wb_stb_i),
    .we_i          (wb_we_i),
    .adr_i         (wb_adr_i),
    .dat_i         (wb_dat_i),
    .dat_o         (wb_dat_o),
    .ack_o         (wb_ack_o),
    .active_i      (sample_o),
    .irq_i         (irq_o),
    .period_o      (period),
    .wr_sample_o   (wr_sample),
    .sample_wdata_o(sample_wdata)
  );

  wbsf_rate_timer #(
    .CNT_W     (CNT_W),
    .RST_RELOAD(RST_RELOAD)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period),
    .tick_o  (tick)
  );

  wbsf_sample_stage #(
    .SAMPLE_W(SAMPLE_W)
  ) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_i    (wr_sample),
    .wdata_i (sample_wdata),
    .sample_o(sample_o),
    .irq_o   (irq_o)
  );

endmodule

// File: tb/sim_wb_sample_feeder.sv
module sim_wb_sample_feeder;

  localparam int P0 = 40;
  localparam int P1 = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [0:0]  adr = '0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic        ack;
  logic [15:0] sample;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  int          cyc_cnt = 0;
  int          last_chg = 0;
  int          exp_period = P0;
  bit          skip_int = 1'b1;
  bit          mon_en = 1'b0;
  logic [15:0] prev_s = '0;
  string       per_tag = "R5";

  wb_sample_feeder #(.RST_RELOAD(P0)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .sample_o(sample), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every change of the active sample
  always @(negedge clk) begin
    if (mon_en && sample !== prev_s) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", sample, prev_s);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(sample == e, "R6", sample, e);
      end
      check(irq == 1'b1, "R6", irq, 1);
      if (skip_int) skip_int = 1'b0;
      else check(cyc_cnt - last_chg == exp_period, per_tag, cyc_cnt - last_chg, exp_period);
      last_chg = cyc_cnt;
      prev_s   = sample;
    end
  end

  task automatic wb_write(input logic [0:0] a, input logic [31:0] d, input bit push);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; dat_i = d;
    if (push) exp_q.push_back(d[15:0]);
    @(negedge clk);
    check(ack == 1'b1, "R2", ack, 1);
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check(ack == 1'b0, "R2", ack, 0);
  endtask

  task automatic wb_read(input logic [0:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk);
    check(ack == 1'b1, "R2", ack, 1);
    d = dat_o;
    cyc = 0; stb = 0;
    @(negedge clk);
    check(ack == 1'b0, "R2", ack, 0);
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [15:0] held;
    bit          seen_ack;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(sample == 16'h0, "R10", sample, 0);
    check(irq == 1'b1, "R10", irq, 1);
    wb_read(1'b1, rd);
    check(rd == 32'(P0), "R10", rd, P0);
    wb_read(1'b0, rd);
    check(rd == 32'h0001_0000, "R4", rd, 32'h0001_0000);
    last_chg = cyc_cnt;
    mon_en   = 1'b1;

    // R2: strobe without cyc is ignored
    @(negedge clk);
    stb = 1; we = 1; adr = 1'b0; dat_i = 32'h0000_BEEF;
    seen_ack = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ack) seen_ack = 1'b1;
    end
    stb = 0; we = 0;
    check(!seen_ack, "R2", seen_ack, 0);
    check(irq == 1'b1, "R2", irq, 1);
    repeat (2 * P0 + 2) @(negedge clk);
    check(sample == 16'h0, "R2", sample, 0);

    // R5/R6: steady stream at the reset period
    for (int i = 0; i < 6; i++) begin
      wait_irq();
      wb_write(1'b0, 32'h1000 + 32'(i) * 32'h0111, 1'b1);
    end
    wait_drain();

    // R7: empty slot at expiry keeps the sample and the interrupt
    held = sample;
    repeat (3 * P0) @(negedge clk);
    check(sample == held, "R7", sample, held);
    check(irq == 1'b1, "R7", irq, 1);
    wb_read(1'b0, rd);
    check(rd == {15'h0, 1'b1, held}, "R4", rd, {15'h0, 1'b1, held});

    // R9/R1: new period starts after the interval in progress
    wb_write(1'b1, 32'hABCD_0000 | 32'(P1), 1'b0);
    wb_read(1'b1, rd);
    check(rd == 32'(P1), "R1", rd, P1);
    skip_int   = 1'b1;
    exp_period = P1;
    per_tag    = "R9";
    for (int i = 0; i < 4; i++) begin
      wb_write(1'b0, 32'h2000 + 32'(i) * 32'h0123, 1'b1);
      wait_irq();
    end
    wait_drain();

    // R3/R8: overwrite of the held sample before expiry
    wait_irq();
    held = sample;
    wb_write(1'b0, 32'h0000_5A5A, 1'b0);
    check(irq == 1'b0, "R3", irq, 0);
    wb_read(1'b0, rd);
    check(rd == {16'h0, held}, "R8", rd, {16'h0, held});
    wb_write(1'b0, 32'hFFFF_C3C3, 1'b1);
    wb_read(1'b0, rd);
    check(rd == {16'h0, held}, "R8", rd, {16'h0, held});
    wait_drain();
    repeat (2 * P1) @(negedge clk);
    check(sample == 16'hC3C3, "R8", sample, 16'hC3C3);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule